// File: doc/BRIEF.md
# Banked GPIO Controller with Event Interrupts

This block is a memory-mapped general-purpose I/O controller with three banks of 32 pins each, 96 pins in all. Software reaches it through a 32-bit register port. Each bank has its own set of registers for pin direction, input inversion, an output latch, and write-one-to-set and write-one-to-clear views of that latch. The pad side sees three flat vectors: synchronous inputs, output values and output enables.

Every input pin passes through a two-stage synchronizer and then through an optional inversion. The result feeds four independent detectors: rising edge, falling edge, high level and low level. Any enabled detector that fires latches the pin's pending bit. A companion read-only bit records whether an edge caused the pending bit. One interrupt line stays high while any pending bit in any bank is set. Software clears pending bits by writing ones.

The register port is single-cycle. A write commits on the clock edge while the write strobe is high. Read data is combinational from the address.

Top module: `gpio_bank_ctl`

## Requirements
- R1: After reset, every register reads zero, all outputs and output enables are low, and the interrupt is low.
- R2: The address is a byte address. Bits [7:4] select the register group: 0 direction, 1 inversion, 2 data, 3 set, 4 clear, 5 rising enable, 6 falling enable, 7 high enable, 8 low enable, 9 pending, 10 edge cause. Bits [3:2] select the bank. An address with bits [1:0] nonzero, a bank of 3, or a group above 10 is unmapped: it reads zero and writes to it change nothing. The set and clear groups read zero.
- R3: A write to the set group drives high every output bit written as 1. A write to the clear group drives low every output bit written as 1. Bits written as 0 are left unchanged. A write to the data group loads the latch directly.
- R4: A direction bit of 1 makes the pin an output, and the pin's output enable follows that bit. A data read returns the latch for output pins and the conditioned input for input pins.
- R5: An inversion bit of 1 inverts the synchronized input before it is read and before events are detected.
- R6: A change on a pin input shows in a data read after two clock edges, and reaches the pending register on the third edge.
- R7: A rising enable latches a pending bit on a 0-to-1 transition of the conditioned input, and a falling enable does so on a 1-to-0 transition. With both enabled, the pin reports either edge. A transition with no matching enable latches nothing.
- R8: A level enable sets the pending bit on every clock in which the matching level is present. If the level persists, the bit stays set through a clear.
- R9: Writing 1 to a pending bit clears it, and writing 0 has no effect. An event in the same cycle as a clear wins.
- R10: An edge-cause bit is set when an edge event latches the pending bit. It clears with that pending bit, and it is never set while its pending bit is clear.
- R11: The interrupt output is high exactly while at least one pending bit in any bank is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, committed on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | 96 | Pad inputs, bank n at bits [32n+31:32n] |
| pin_out | output | 96 | Output latch toward the pads |
| pin_oe | output | 96 | Output enables, 1 = driven |
| irq | output | 1 | Shared interrupt, high while any pending bit is set |

## Verification
The hardest case to reach from the ports is a clear that lands in the same clock as a fresh event. This happens with a level enable whose level persists through the write-one-to-clear, and with an edge whose detection coincides with the clear write. The directed part of the stimulus clears a held low-level pin and shows the bit re-latching. A long random phase then toggles pins and writes random registers, including the pending group, on every clock. A cycle-accurate behavioural model in the bench tracks the synchronizer delay with a queue and compares read data, outputs and the interrupt on every clock. This catches coincidences that directed sequences do not line up.

// File: rtl/gpio_bank_ctl.sv
module gpio_bank_ctl #(
  parameter int NB = 3,
  parameter int W  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      bus_addr,
  input  logic            bus_wr,
  input  logic [W-1:0]    bus_wdata,
  output logic [W-1:0]    bus_rdata,
  input  logic [NB*W-1:0] pin_in,
  output logic [NB*W-1:0] pin_out,
  output logic [NB*W-1:0] pin_oe,
  output logic            irq
);

  localparam int NP = NB * W;
  localparam logic [3:0] G_DIR = 4'd0, G_POL = 4'd1, G_DAT = 4'd2, G_SET = 4'd3,
                         G_CLR = 4'd4, G_RISE = 4'd5, G_FALL = 4'd6, G_HI = 4'd7,
                         G_LO = 4'd8, G_STAT = 4'd9, G_EDGE = 4'd10;

  logic [NP-1:0] dir_q, pol_q, out_q, ren_q, fen_q, hen_q, len_q;
  logic [NP-1:0] stat_q, edge_q, sync1_q, sync2_q, prev_q;

  wire [3:0] grp     = bus_addr[7:4];
  wire [1:0] bsel    = bus_addr[3:2];
  wire       addr_ok = (bus_addr[1:0] == 2'b00) && (int'(bsel) < NB);

  wire [NP-1:0] fmask = addr_ok ? ({{(NP-W){1'b0}}, {W{1'b1}}} << (bsel * W)) : '0;
  wire [NP-1:0] wdat  = ({{(NP-W){1'b0}}, bus_wdata} << (bsel * W)) & fmask;

  function automatic logic [NP-1:0] merge(input logic [NP-1:0] old);
    return (old & ~fmask) | wdat;
  endfunction

  // conditioned input and event detection
  wire [NP-1:0] cur    = sync2_q ^ pol_q;
  wire [NP-1:0] rise   = cur & ~prev_q;
  wire [NP-1:0] fall   = ~cur & prev_q;
  wire [NP-1:0] edg_ev = (ren_q & rise) | (fen_q & fall);
  wire [NP-1:0] lvl_ev = (hen_q & cur) | (len_q & ~cur);
  wire [NP-1:0] ev     = edg_ev | lvl_ev;
  wire [NP-1:0] clr_v  = (bus_wr && grp == G_STAT) ? wdat : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      stat_q  <= '0;
      edge_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= cur;
      stat_q  <= (stat_q & ~clr_v) | ev;
      edge_q  <= (edge_q & ~clr_v) | edg_ev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      pol_q <= '0;
      out_q <= '0;
      ren_q <= '0;
      fen_q <= '0;
      hen_q <= '0;
      len_q <= '0;
    end else if (bus_wr) begin
      case (grp)
        G_DIR:   dir_q <= merge(dir_q);
        G_POL:   pol_q <= merge(pol_q);
        G_DAT:   out_q <= merge(out_q);
        G_SET:   out_q <= out_q | wdat;
        G_CLR:   out_q <= out_q & ~wdat;
        G_RISE:  ren_q <= merge(ren_q);
        G_FALL:  fen_q <= merge(fen_q);
        G_HI:    hen_q <= merge(hen_q);
        G_LO:    len_q <= merge(len_q);
        default: ;
      endcase
    end
  end

  logic [NP-1:0] rd_vec;
  always_comb begin
    case (grp)
      G_DIR:   rd_vec = dir_q;
      G_POL:   rd_vec = pol_q;
      G_DAT:   rd_vec = (dir_q & out_q) | (~dir_q & cur);
      G_RISE:  rd_vec = ren_q;
      G_FALL:  rd_vec = fen_q;
      G_HI:    rd_vec = hen_q;
      G_LO:    rd_vec = len_q;
      G_STAT:  rd_vec = stat_q;
      G_EDGE:  rd_vec = edge_q;
      default: rd_vec = '0;
    endcase
  end

  wire [NP-1:0] rd_sh = rd_vec >> (bsel * W);
  assign bus_rdata = addr_ok ? rd_sh[W-1:0] : '0;
  assign pin_out   = out_q;
  assign pin_oe    = dir_q;
  assign irq       = |stat_q;

  assert_edge_has_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q & ~stat_q) == '0);

  assert_level_relatches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_ev != '0) |=> ((stat_q & $past(lvl_ev)) == $past(lvl_ev)));

  assert_irq_needs_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev != '0));

  assert_oe_only_by_dir_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && grp == G_DIR) |=> $stable(pin_oe));

  for (genvar b = 0; b < NB; b++) begin : g_bank_chk
    assert_set_drives_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 8'(8'h30 + 4 * b)) |=>
        ((pin_out[b*W +: W] & $past(bus_wdata)) == $past(bus_wdata)));

    assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 8'(8'h90 + 4 * b)) |=>
        ((stat_q[b*W +: W] & $past(bus_wdata) & ~$past(ev[b*W +: W])) == '0));
  end

endmodule

// File: tb/gpio_bank_ctl_bench.sv
`timescale 1ns/1ps
module gpio_bank_ctl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [95:0] pin_in = '0;
  logic [95:0] pin_out, pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_bank_ctl u_gpio_bank_ctl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [95:0] m_dir, m_pol, m_out, m_ren, m_fen, m_hen, m_len, m_st, m_eg, m_prev, m_sync;
  logic [95:0] m_q[$];

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [95:0] v;
    int g, b;
    g = int'(a[7:4]);
    b = int'(a[3:2]);
    if (a[1:0] != 2'b00 || b >= 3) return 32'h0;
    case (g)
      0: v = m_dir;
      1: v = m_pol;
      2: v = (m_dir & m_out) | (~m_dir & (m_sync ^ m_pol));
      5: v = m_ren;
      6: v = m_fen;
      7: v = m_hen;
      8: v = m_len;
      9: v = m_st;
      10: v = m_eg;
      default: v = '0;
    endcase
    return 32'(v >> (b * 32));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '0; m_pol = '0; m_out = '0; m_ren = '0; m_fen = '0;
      m_hen = '0; m_len = '0; m_st = '0; m_eg = '0; m_prev = '0; m_sync = '0;
      m_q = {};
      m_q.push_back('0);
    end else begin
      logic [95:0] c, e_edge, e_all, wv, fm;
      int g, b;
      c = m_sync ^ m_pol;
      e_edge = (m_ren & c & ~m_prev) | (m_fen & ~c & m_prev);
      e_all = e_edge | (m_hen & c) | (m_len & ~c);
      g = int'(bus_addr[7:4]);
      b = int'(bus_addr[3:2]);
      wv = '0;
      fm = '0;
      if (bus_wr && bus_addr[1:0] == 2'b00 && b < 3) begin
        fm = {64'h0, 32'hFFFF_FFFF} << (b * 32);
        wv = {64'h0, bus_wdata} << (b * 32);
      end
      m_st = (m_st & ~((g == 9) ? wv : 96'h0)) | e_all;
      m_eg = (m_eg & ~((g == 9) ? wv : 96'h0)) | e_edge;
      m_prev = c;
      case (g)
        0: m_dir = (m_dir & ~fm) | wv;
        1: m_pol = (m_pol & ~fm) | wv;
        2: m_out = (m_out & ~fm) | wv;
        3: m_out = m_out | wv;
        4: m_out = m_out & ~wv;
        5: m_ren = (m_ren & ~fm) | wv;
        6: m_fen = (m_fen & ~fm) | wv;
        7: m_hen = (m_hen & ~fm) | wv;
        8: m_len = (m_len & ~fm) | wv;
        default: ;
      endcase
      m_sync = m_q.pop_front();
      m_q.push_back(pin_in);
    end
  end

  // compare against the model on every clock
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R4 pin_oe vs model", pin_oe, m_dir);
      chk("R3 pin_out vs model", pin_out, m_out);
      chk("R11 irq vs model", {95'h0, irq}, {95'h0, (m_st != '0)});
      chk("R2 rdata vs model", {64'h0, bus_rdata}, {64'h0, m_read(bus_addr)});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, {64'h0, bus_rdata}, {64'h0, exp});
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int g = 0; g <= 10; g++)
      for (int b = 0; b < 3; b++)
        rd("R1 register after reset", 8'(g * 16 + b * 4), 32'h0);
    chk("R1 pin_oe after reset", pin_oe, '0);
    chk("R1 pin_out after reset", pin_out, '0);
    chk("R1 irq after reset", {95'h0, irq}, '0);

    // R3 / R4: direction, latch, set and clear on bank 1
    wr(8'h04, 32'hFF);
    wr(8'h24, 32'h12);
    wr(8'h34, 32'hF0);
    rd("R3 set ors ones", 8'h24, 32'hF2);
    wr(8'h44, 32'h03);
    rd("R3 clear removes ones", 8'h24, 32'hF0);
    chk("R3 pin_out bank1", pin_out, {32'h0, 32'hF0, 32'h0});
    chk("R4 pin_oe bank1", pin_oe, {32'h0, 32'hFF, 32'h0});
    @(negedge clk);
    pin_in[40] = 1'b1;
    pin_in[32] = 1'b1;
    wait_n(2);
    rd("R4 data mixes latch and input", 8'h24, 32'h1F0);

    // R2: unmapped addresses
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    wr(8'hB0, 32'hFFFF_FFFF);
    chk("R2 unmapped write leaves pin_oe", pin_oe, {32'h0, 32'hFF, 32'h0});
    rd("R2 bank3 reads zero", 8'h0C, 32'h0);
    rd("R2 group above edge reads zero", 8'hB0, 32'h0);
    rd("R2 misaligned reads zero", 8'h05, 32'h0);
    rd("R2 set group reads zero", 8'h34, 32'h0);
    rd("R2 direction bank1", 8'h04, 32'hFF);

    // R6: synchronizer latency on bank 2 bit 5
    @(negedge clk);
    bus_addr = 8'h28;
    pin_in[69] = 1'b1;
    @(negedge clk);
    rd("R6 one edge not yet visible", 8'h28, 32'h0);
    @(negedge clk);
    rd("R6 two edges visible", 8'h28, 32'h20);

    // R5: inversion on read and on detection
    wr(8'h18, 32'h20);
    rd("R5 inverted read", 8'h28, 32'h0);
    wr(8'h10, 32'h4);
    wait_n(2);
    wr(8'h50, 32'h4);
    @(negedge clk);
    pin_in[2] = 1'b1;
    wait_n(4);
    rd("R5 inverted rise of pad not a rising event", 8'h90, 32'h0);
    pin_in[2] = 1'b0;
    wait_n(4);
    rd("R5 inverted fall of pad is a rising event", 8'h90, 32'h4);
    wr(8'h50, 32'h0);
    wr(8'h90, 32'h4);
    wr(8'h10, 32'h0);
    wait_n(2);
    rd("R9 cleared after inversion test", 8'h90, 32'h0);

    // R7 / R10 / R11: edges on bank 0 bit 0
    wr(8'h50, 32'h1);
    @(negedge clk);
    pin_in[0] = 1'b1;
    wait_n(2);
    rd("R6 pending not set after two edges", 8'h90, 32'h0);
    @(negedge clk);
    rd("R7 rising latched on third edge", 8'h90, 32'h1);
    rd("R10 edge cause set", 8'hA0, 32'h1);
    chk("R11 irq with pending", {95'h0, irq}, {95'h0, 1'b1});
    wr(8'h90, 32'h1);
    rd("R9 w1c clears", 8'h90, 32'h0);
    rd("R10 edge cause cleared", 8'hA0, 32'h0);
    chk("R11 irq drops", {95'h0, irq}, '0);
    pin_in[0] = 1'b0;
    wait_n(4);
    rd("R7 fall ignored with only rising", 8'h90, 32'h0);
    wr(8'h60, 32'h1);
    pin_in[0] = 1'b1;
    wait_n(4);
    rd("R7 both enables rise", 8'h90, 32'h1);
    wr(8'h90, 32'h1);
    pin_in[0] = 1'b0;
    wait_n(4);
    rd("R7 both enables fall", 8'h90, 32'h1);
    rd("R10 edge cause on fall", 8'hA0, 32'h1);
    wr(8'h90, 32'h1);
    rd("R9 cleared after fall", 8'h90, 32'h0);

    // R8 / R9: low level on bank 0 bit 1
    wr(8'h80, 32'h2);
    @(negedge clk);
    rd("R8 low level latches", 8'h90, 32'h2);
    rd("R10 level gives no edge cause", 8'hA0, 32'h0);
    wr(8'h90, 32'h0);
    rd("R9 writing zero has no effect", 8'h90, 32'h2);
    wr(8'h90, 32'h2);
    rd("R8 persisting level relatches over clear", 8'h90, 32'h2);
    wr(8'h80, 32'h0);
    wr(8'h90, 32'h2);
    rd("R9 clear after level removed", 8'h90, 32'h0);
    chk("R11 irq low when all clear", {95'h0, irq}, '0);

    // random phase, checked by the model every clock
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) pin_in = {$urandom, $urandom, $urandom};
      bus_addr = 8'($urandom_range(0, 47) * 4 + (($urandom_range(0, 15) == 0) ? 1 : 0));
      bus_wdata = $urandom;
      bus_wr = ($urandom_range(0, 2) == 0);
    end
    @(negedge clk);
    bus_wr = 1'b0;
    wait_n(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule